// File: doc/BRIEF.md
# I2C Burst FIFO Controller

This block sits between software-facing FIFOs and the byte engine of an I2C master and moves whole bursts of data without per-byte supervision. A read burst starts with one write of a receive control byte. Its low seven bits give the byte count and bit 7 asks for the final byte to be answered with NAK. The block then asks the byte engine for that many read bytes, stores each one in a 64-entry receive FIFO, and raises a read-complete flag once the last one is stored. Software drains the bytes through a show-ahead read-out port.

For writes, bytes pushed into a 64-entry transmit FIFO are handed to the byte engine one at a time while the FIFO is enabled. A NAK from the slave stops the drain at once and raises a no-acknowledge flag. Nothing more is sent until a flush clears the leftover bytes. A transmit control byte carries flush (bit 7) and enable (bit 6). A status byte reports both FIFOs' empty state. Start, stop and address phases belong to the surrounding master and are not generated here.

Top module: `i2c_burst_fifo_ctrl`

## Requirements
- R1: A receive control write with count field bits[6:0] = n requests exactly n read bytes from the byte engine. A count above 64 is treated as 64.
- R2: With bit 7 of the receive control byte set, the final byte of the burst is requested with `eng_nak_last` high and every earlier byte with it low. With bit 7 clear, `eng_nak_last` stays low for every byte.
- R3: Flag bit 0 (read-complete) rises in the cycle after the last burst byte is stored. `rx_byte` shows the oldest stored byte, and `rx_pop` advances it, so bytes come out in arrival order.
- R4: A count of zero issues no byte-engine request and sets read-complete in the cycle after the control write.
- R5: A receive control write that arrives while a burst still has bytes outstanding is ignored.
- R6: While enabled, the transmit FIFO is sent one byte per engine request, in push order. While disabled, nothing is sent.
- R7: A NAK reported on a write byte sets flag bit 1 (no-acknowledge). No further write byte is requested until a flush.
- R8: A transmit control write with reserved bits[5:0] zero sets the enable to bit 6 and, if bit 7 is set, empties the transmit FIFO and lifts a NAK halt. A transmit control write with any reserved bit set is ignored.
- R9: `fifo_stat` bit 2 is receive-empty and bit 4 is transmit-empty. All other bits read 0. After reset both FIFOs are empty and all flags are 0.
- R10: A push into a full transmit FIFO is dropped and sets flag bit 2 (error). Writing 1 to a bit of `flag_clr` clears that flag, unless the flag is being set in the same cycle.
- R11: `eng_req` stays high, with `eng_rd` and `eng_wdata` stable, until `eng_done` is seen. The byte engine then gets one idle cycle before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxc_wr | input | 1 | Receive control write strobe |
| rxc_data | input | 8 | Receive control: [6:0] count, [7] NAK final byte |
| txc_wr | input | 1 | Transmit control write strobe |
| txc_data | input | 8 | Transmit control: [7] flush, [6] enable, [5:0] reserved |
| tx_push | input | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | input | DW | Byte to push |
| rx_pop | input | 1 | Remove the oldest receive byte |
| rx_byte | output | DW | Oldest receive byte (show-ahead) |
| fifo_stat | output | 8 | [2] receive empty, [4] transmit empty |
| flag_clr | input | 3 | Write-1-to-clear: [0] read-complete, [1] NAK, [2] error |
| flags | output | 3 | [0] read-complete, [1] NAK, [2] error |
| eng_req | output | 1 | Byte engine request |
| eng_rd | output | 1 | Request is a read (1) or a write (0) |
| eng_wdata | output | DW | Byte to write |
| eng_nak_last | output | 1 | Answer this read byte with NAK |
| eng_done | input | 1 | Byte engine finished the current byte |
| eng_rdata | input | DW | Byte read by the engine, valid with `eng_done` |
| eng_nak | input | 1 | Slave answered the write byte with NAK, valid with `eng_done` |

## Verification
A remaining-count register that is off by one shows up at the engine port within the burst. The number of read requests comes out wrong, and the NAK request lands on the wrong byte. A read pointer or occupancy error shows up on the first pop as a wrong `rx_byte` or a wrong empty bit. A lost NAK halt shows up one idle cycle after the NAK'd byte, as an extra write request. A flush that fails to clear shows up the next cycle as a stale transmit-empty bit.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RD   = 2'd1,
      SQ_WR   = 2'd2
   } sq_state_e;

   // receive control byte
   localparam int RXC_NAK_BIT      = 7;
   localparam int RXC_CNT_W        = 7;
   // transmit control byte
   localparam int TXC_FLUSH_BIT    = 7;
   localparam int TXC_EN_BIT       = 6;
   localparam int TXC_RSV_W        = 6;
   // status byte
   localparam int FST_RX_EMPTY_BIT = 2;
   localparam int FST_TX_EMPTY_BIT = 4;
   // sticky flags
   localparam int FLG_RDDONE       = 0;
   localparam int FLG_NACK         = 1;
   localparam int FLG_ERR          = 2;
   localparam int FLG_N            = 3;
endpackage

// File: rtl/i2cb_fifo.sv
module i2cb_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          empty,
   output logic          full,
   output logic          drop
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2) else $error("i2cb_fifo: DEPTH must be at least 2");
      assert (DW >= 1)    else $error("i2cb_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign drop    = push && full && !flush;
   assign dout    = mem[rp];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wp_nx = wp + AW'(1);
         assign rp_nx = rp + AW'(1);
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   a_r10_full_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop && !flush |=> full && $stable(rp));
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   a_r3_pop_empty_safe: assert property (@(posedge clk) disable iff (!rst_n)
      empty && pop && !push |=> empty);
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
   import i2cb_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_start,
   input  logic [CW-1:0] rd_count,
   input  logic          rd_nak_en,
   input  logic          tx_en,
   input  logic          tx_flush,
   input  logic          tx_empty,
   input  logic [DW-1:0] tx_head,
   output logic          tx_pop,
   output logic          rx_push,
   output logic [DW-1:0] rx_din,
   output logic          rd_fin,
   output logic          nack_ev,
   output logic          eng_req,
   output logic          eng_rd,
   output logic [DW-1:0] eng_wdata,
   output logic          eng_nak_last,
   input  logic          eng_done,
   input  logic [DW-1:0] eng_rdata,
   input  logic          eng_nak
);
   sq_state_e     state;
   logic [CW-1:0] rd_rem;
   logic          nak_q;
   logic [DW-1:0] wbyte;
   logic          halted;
   logic          rd_accept, wr_go, rd_go, done_rd, done_wr;

   assign rd_accept = rd_start && (rd_rem == '0);
   assign rd_go     = (state == SQ_IDLE) && (rd_rem != '0);
   assign wr_go     = (state == SQ_IDLE) && (rd_rem == '0) && tx_en &&
                      !tx_empty && !halted && !tx_flush;
   assign done_rd   = (state == SQ_RD) && eng_done;
   assign done_wr   = (state == SQ_WR) && eng_done;

   assign tx_pop    = wr_go;
   assign rx_push   = done_rd;
   assign rx_din    = eng_rdata;
   assign rd_fin    = (rd_accept && (rd_count == '0)) ||
                      (done_rd && (rd_rem == CW'(1)));
   assign nack_ev   = done_wr && eng_nak;

   assign eng_req      = (state != SQ_IDLE);
   assign eng_rd       = (state == SQ_RD);
   assign eng_wdata    = wbyte;
   assign eng_nak_last = (state == SQ_RD) && nak_q && (rd_rem == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         rd_rem <= '0;
         nak_q  <= 1'b0;
         wbyte  <= '0;
         halted <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (rd_go)      state <= SQ_RD;
               else if (wr_go) state <= SQ_WR;
            end
            SQ_RD:   if (eng_done) state <= SQ_IDLE;
            SQ_WR:   if (eng_done) state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase

         if (rd_accept) begin
            rd_rem <= rd_count;
            nak_q  <= rd_nak_en;
         end else if (done_rd) begin
            rd_rem <= rd_rem - CW'(1);
         end

         if (wr_go) wbyte <= tx_head;

         if (tx_flush)     halted <= 1'b0;
         else if (nack_ev) halted <= 1'b1;
      end
   end

   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && !eng_done |=> eng_req && $stable(eng_rd) && $stable(eng_wdata));
   a_r11_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && eng_done |=> !eng_req);
   a_r7_halt_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      halted && (state == SQ_IDLE) |=> state != SQ_WR);
   a_r2_nak_on_final: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && eng_rd && eng_nak_last && eng_done |=> rd_rem == '0);
   a_r4_zero_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      rd_accept && (rd_count == '0) |=> rd_rem == '0);
endmodule

// File: rtl/i2cb_flags.sv
module i2cb_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
         end
         a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
      end
   endgenerate
endmodule

// File: rtl/i2c_burst_fifo_ctrl.sv
module i2c_burst_fifo_ctrl
   import i2cb_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rxc_wr,
   input  logic [7:0]    rxc_data,
   input  logic          txc_wr,
   input  logic [7:0]    txc_data,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_byte,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_byte,
   output logic [7:0]    fifo_stat,
   input  logic [2:0]    flag_clr,
   output logic [2:0]    flags,
   output logic          eng_req,
   output logic          eng_rd,
   output logic [DW-1:0] eng_wdata,
   output logic          eng_nak_last,
   input  logic          eng_done,
   input  logic [DW-1:0] eng_rdata,
   input  logic          eng_nak
);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH < (1 << RXC_CNT_W))
         else $error("i2c_burst_fifo_ctrl: DEPTH exceeds count field");
   end

   logic [RXC_CNT_W-1:0] cnt_raw;
   logic [CW-1:0]        cnt_clamped;
   logic                 txc_ok, tx_flush, tx_en;
   logic                 tx_empty, tx_full, tx_drop, tx_pop;
   logic [DW-1:0]        tx_head;
   logic                 rx_empty, rx_full, rx_drop, rx_push;
   logic [DW-1:0]        rx_din;
   logic                 rd_fin, nack_ev;
   logic [FLG_N-1:0]     flag_set;

   assign cnt_raw     = rxc_data[RXC_CNT_W-1:0];
   assign cnt_clamped = (cnt_raw > RXC_CNT_W'(DEPTH)) ? CW'(DEPTH) : CW'(cnt_raw);

   assign txc_ok   = txc_wr && (txc_data[TXC_RSV_W-1:0] == '0);
   assign tx_flush = txc_ok && txc_data[TXC_FLUSH_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tx_en <= 1'b0;
      else if (txc_ok) tx_en <= txc_data[TXC_EN_BIT];
   end

   i2cb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(tx_push), .din(tx_byte), .pop(tx_pop),
      .dout(tx_head), .empty(tx_empty), .full(tx_full), .drop(tx_drop)
   );

   i2cb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(1'b0),
      .push(rx_push), .din(rx_din), .pop(rx_pop),
      .dout(rx_byte), .empty(rx_empty), .full(rx_full), .drop(rx_drop)
   );

   i2cb_seq #(.DW(DW), .CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .rd_start(rxc_wr), .rd_count(cnt_clamped),
      .rd_nak_en(rxc_data[RXC_NAK_BIT]),
      .tx_en(tx_en), .tx_flush(tx_flush), .tx_empty(tx_empty),
      .tx_head(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_din(rx_din),
      .rd_fin(rd_fin), .nack_ev(nack_ev),
      .eng_req(eng_req), .eng_rd(eng_rd), .eng_wdata(eng_wdata),
      .eng_nak_last(eng_nak_last), .eng_done(eng_done),
      .eng_rdata(eng_rdata), .eng_nak(eng_nak)
   );

   always_comb begin
      flag_set             = '0;
      flag_set[FLG_RDDONE] = rd_fin;
      flag_set[FLG_NACK]   = nack_ev;
      flag_set[FLG_ERR]    = tx_drop || rx_drop;
   end

   i2cb_flags #(.N(FLG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flags)
   );

   always_comb begin
      fifo_stat                   = '0;
      fifo_stat[FST_RX_EMPTY_BIT] = rx_empty;
      fifo_stat[FST_TX_EMPTY_BIT] = tx_empty;
   end

   a_r10_tx_full_is_err: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push && tx_full && !tx_flush |=> flags[FLG_ERR]);
   a_r3_done_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && rd_fin && !rx_full |=> !rx_empty);
   a_r6_disabled_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en && !eng_req |=> !(eng_req && !eng_rd));
endmodule

// File: tb/i2c_burst_fifo_ctrl_tb.sv
module i2c_burst_fifo_ctrl_tb;
   localparam int DW = 8;
   localparam int DEPTH = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rxc_wr = 1'b0, txc_wr = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0]    rxc_data = '0, txc_data = '0;
   logic [DW-1:0] tx_byte = '0;
   logic [DW-1:0] rx_byte;
   logic [7:0]    fifo_stat;
   logic [2:0]    flag_clr = '0;
   logic [2:0]    flags;
   logic          eng_req, eng_rd, eng_nak_last;
   logic [DW-1:0] eng_wdata;
   logic          eng_done = 1'b0, eng_nak = 1'b0;
   logic [DW-1:0] eng_rdata = '0;

   int n_chk = 0, n_fail = 0;
   int rd_idx = 0, wr_idx = 0, nak_at = 999, wcnt = 0;
   logic          rec_nl [128];
   logic [7:0]    wr_log [256];

   always #5 clk = ~clk;

   i2c_burst_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .rxc_wr(rxc_wr), .rxc_data(rxc_data),
      .txc_wr(txc_wr), .txc_data(txc_data), .tx_push(tx_push), .tx_byte(tx_byte),
      .rx_pop(rx_pop), .rx_byte(rx_byte), .fifo_stat(fifo_stat),
      .flag_clr(flag_clr), .flags(flags), .eng_req(eng_req), .eng_rd(eng_rd),
      .eng_wdata(eng_wdata), .eng_nak_last(eng_nak_last), .eng_done(eng_done),
      .eng_rdata(eng_rdata), .eng_nak(eng_nak)
   );

   function automatic logic [7:0] rpat(int i);
      return 8'((i * 29 + 11) & 255);
   endfunction
   function automatic logic [7:0] wpat(int n, int i);
      return 8'((i * 13 + n * 3 + 1) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // byte engine model: done two cycles after a request is seen
   initial begin
      forever begin
         @(negedge clk);
         if (eng_done) begin
            eng_done = 1'b0;
            eng_nak  = 1'b0;
         end else if (eng_req) begin
            wcnt++;
            if (wcnt == 2) begin
               wcnt = 0;
               eng_done = 1'b1;
               if (eng_rd) begin
                  eng_rdata = rpat(rd_idx);
                  if (rd_idx < 128) rec_nl[rd_idx] = eng_nak_last;
                  rd_idx++;
               end else begin
                  if (wr_idx < 256) wr_log[wr_idx] = eng_wdata;
                  eng_nak = (wr_idx == nak_at);
                  wr_idx++;
               end
            end
         end
      end
   end

   task automatic cyc(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic clr_flags();
      flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000;
   endtask

   task automatic txc(input logic [7:0] v);
      txc_wr = 1'b1; txc_data = v; @(negedge clk); txc_wr = 1'b0;
   endtask

   task automatic push(input logic [7:0] v);
      tx_push = 1'b1; tx_byte = v; @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic pop_check(input int n, input string req);
      int mism = 0;
      for (int i = 0; i < n; i++) begin
         if (rx_byte !== rpat(i)) mism++;
         rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
      end
      chk(mism == 0, req, mism, 0);
      chk(fifo_stat[2] == 1'b1, "R9 rx empty after drain", fifo_stat[2], 1);
   endtask

   task automatic do_read(input int n, input bit ne);
      int expn, mism, w;
      expn = (n > 64) ? 64 : n;
      clr_flags();
      rd_idx = 0;
      rxc_wr = 1'b1; rxc_data = {ne, 7'(n)};
      @(negedge clk);
      rxc_wr = 1'b0;
      if (n == 0) begin
         chk(flags[0] == 1'b1, "R4 zero count done next cycle", flags[0], 1);
         cyc(10);
         chk(rd_idx == 0, "R4 zero count no bus", rd_idx, 0);
         chk(fifo_stat[2] == 1'b1, "R9 rx empty", fifo_stat[2], 1);
      end else begin
         w = 0;
         while (!flags[0] && w < 600) begin @(negedge clk); w++; end
         chk(flags[0] == 1'b1, "R3 read-complete raised", flags[0], 1);
         chk(rd_idx == expn, "R1 read byte count", rd_idx, expn);
         mism = 0;
         for (int i = 0; i < expn; i++)
            if (rec_nl[i] !== (ne && (i == expn - 1))) mism++;
         chk(mism == 0, "R2 nak-last pattern", mism, 0);
         chk(fifo_stat[2] == 1'b0, "R9 rx not empty", fifo_stat[2], 0);
         pop_check(expn, "R3 rx data order");
      end
   endtask

   task automatic do_write(input int n, input int nk);
      int sent, mism;
      txc(8'h80);
      clr_flags();
      wr_idx = 0; nak_at = nk;
      for (int i = 0; i < n; i++) push(wpat(n, i));
      cyc(10);
      chk(wr_idx == 0, "R6 disabled sends nothing", wr_idx, 0);
      txc(8'h40);
      cyc(n * 6 + 20);
      sent = (nk < n) ? nk + 1 : n;
      chk(wr_idx == sent, "R6 bytes sent", wr_idx, sent);
      mism = 0;
      for (int i = 0; i < sent; i++) if (wr_log[i] !== wpat(n, i)) mism++;
      chk(mism == 0, "R6 write order", mism, 0);
      chk(flags[1] == (nk < n), "R7 nack flag", flags[1], (nk < n));
      chk(fifo_stat[4] == (sent == n), "R9 tx empty", fifo_stat[4], (sent == n));
      if (nk < n) begin
         cyc(30);
         chk(wr_idx == sent, "R7 halted after nak", wr_idx, sent);
         txc(8'hC0);
         chk(fifo_stat[4] == 1'b1, "R8 flush empties tx", fifo_stat[4], 1);
         nak_at = 999;
         push(8'hA5);
         cyc(20);
         chk(wr_idx == sent + 1, "R8 flush lifts halt", wr_idx, sent + 1);
         chk(wr_log[sent] == 8'hA5, "R8 post-flush byte", wr_log[sent], 8'hA5);
      end
      nak_at = 999;
   endtask

   initial begin
      int w;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk(fifo_stat == 8'h14, "R9 reset status", fifo_stat, 8'h14);
      chk(flags == 3'b000, "R9 reset flags", flags, 0);
      chk(eng_req == 1'b0, "R11 reset no request", eng_req, 0);

      // reads: sweep every count both with and without final NAK
      for (int n = 0; n <= 64; n++) begin
         do_read(n, 1'b0);
         do_read(n, 1'b1);
      end
      do_read(127, 1'b1);   // R1 clamp
      do_read(65, 1'b0);    // R1 clamp

      // R5: second control write during a burst
      clr_flags();
      rd_idx = 0;
      rxc_wr = 1'b1; rxc_data = 8'd10; @(negedge clk);
      rxc_data = 8'd3; @(negedge clk);
      rxc_wr = 1'b0;
      w = 0;
      while (!flags[0] && w < 200) begin @(negedge clk); w++; end
      cyc(10);
      chk(rd_idx == 10, "R5 busy write ignored", rd_idx, 10);
      pop_check(10, "R5 data of first burst");

      // R10 flag write-1-clear keeps other bits
      chk(flags[0] == 1'b1, "R10 done before clear", flags[0], 1);
      flag_clr = 3'b100; @(negedge clk); flag_clr = 3'b000;
      chk(flags[0] == 1'b1, "R10 clear other bit only", flags[0], 1);
      flag_clr = 3'b001; @(negedge clk); flag_clr = 3'b000;
      chk(flags[0] == 1'b0, "R10 clear read-complete", flags[0], 0);

      // writes: every length, then NAK positions
      for (int n = 1; n <= 64; n++) do_write(n, 999);
      do_write(1, 0);
      do_write(5, 0);
      do_write(5, 2);
      do_write(5, 4);
      do_write(64, 0);
      do_write(64, 31);
      do_write(64, 63);

      // R10 overflow
      txc(8'h80);
      clr_flags();
      wr_idx = 0;
      for (int i = 0; i < 64; i++) push(wpat(99, i));
      chk(flags[2] == 1'b0, "R10 no error at 64", flags[2], 0);
      push(8'hEE);
      chk(flags[2] == 1'b1, "R10 overflow error", flags[2], 1);
      // R8 reserved bits set: ignored
      txc(8'hC1);
      cyc(20);
      chk(fifo_stat[4] == 1'b0, "R8 reserved write no flush", fifo_stat[4], 0);
      chk(wr_idx == 0, "R8 reserved write no enable", wr_idx, 0);
      txc(8'h40);
      cyc(64 * 6 + 20);
      chk(wr_idx == 64, "R10 dropped byte not sent", wr_idx, 64);
      chk(wr_log[63] == wpat(99, 63), "R10 last kept byte", wr_log[63], wpat(99, 63));
      chk(fifo_stat == 8'h14, "R9 both empty", fifo_stat, 8'h14);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 190000; c++) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule